// File: doc/BRIEF.md
# Subranging Converter Correction Logic

This block is the digital back end of a two-step subranging analog-to-digital converter. It drives the strobes that sequence one conversion: hold the sample, resolve the coarse code, resolve the fine code, then latch the result. It then merges the coarse code from the N1-bit first-stage flash with the fine stage's comparator outputs into one N-bit word, where N = N1 + N2. The fine flash has EXTRA redundant comparators above and below its nominal 2^N2 - 1 levels. A residue that leaves the nominal span is still resolved, and the block corrects it digitally. The fine code wraps around and the coarse code moves by one step. This removes the missing codes caused by a misaligned residue.

A build option (POS_ONLY) assumes that the analog side adds a fixed offset to the residue, so that it never goes negative. In that variant all comparator levels are counted upward from zero, and the coarse code is either passed through or incremented. Results that would leave the N-bit span are clamped, and a sticky flag records that this happened. Each finished word comes with a one-cycle valid pulse.

Top module: `subrange_corrector`

## Requirements
- R1: The output word carries the corrected coarse code in its upper N1 bits and the fine code in its lower N2 bits. With the default variant, the fine value is the number of asserted comparators minus EXTRA. When that value lies in 0..2^N2-1, the coarse code passes unchanged and the result is coarse*2^N2 + fine.
- R2: A start seen while idle produces this sequence: hold_o high for three cycles, coarse_strobe_o in the second of them, fine_strobe_o in the third, then latch_o for one cycle with hold_o low. At most one of the coarse, fine, latch and valid strobes is high in any cycle.
- R3: A fine value of 2^N2 or more sets the fine field to the value minus 2^N2 and adds one to the coarse code.
- R4: In the default variant, a negative fine value of -k makes the fine field 2^N2 - k (so -1 gives all ones) and subtracts one from the coarse code.
- R5: With POS_ONLY = 1, the fine value is the plain comparator count with no offset subtracted. The coarse code is never decremented; it is only passed through or incremented.
- R6: A corrected value above 2^N-1 gives all ones and a value below zero gives all zeros. Either case sets oor_o, which stays high until reset.
- R7: A single wrong comparator output is corrected before counting when at least two correct comparators stand between it and the ones-to-zeros edge of the thermometer. This covers a zero among the ones and a one among the zeros.
- R8: valid_o is high for exactly the one cycle after the latch cycle. result_o holds its value until the next such pulse.
- R9: start_i is ignored while a conversion is in progress, including in the latch cycle.
- R10: The coarse code is sampled at the clock edge that ends the coarse_strobe_o cycle. The fine comparators are sampled at the edge that ends the fine_strobe_o cycle. Later changes to either input do not alter that conversion's result.
- R11: After reset, result_o is zero and valid_o, oor_o, hold_o and all strobes are low.
- R12: In the default variant, with coarse errors of up to one step, every code 0..2^N-1 is produced exactly for an ideal input whenever the resulting residue stays within the redundant comparator range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a conversion (taken only when idle) |
| coarse_i | input | N1 | Coarse code from the first-stage flash |
| fine_therm_i | input | 2^N2-1+2*EXTRA | Fine comparator outputs, bit 0 the lowest level |
| hold_o | output | 1 | Sample-and-hold in hold mode |
| coarse_strobe_o | output | 1 | Coarse conversion cycle |
| fine_strobe_o | output | 1 | Fine conversion cycle |
| latch_o | output | 1 | Result latch cycle |
| result_o | output | N1+N2 | Corrected conversion result |
| valid_o | output | 1 | One-cycle pulse with each new result |
| oor_o | output | 1 | Sticky flag: a result was clamped |

## Verification
The assertions take for granted a synchronous reset held for at least one clock edge, and they rely only on start_i being sampled cleanly. They make no assumption about the comparator vector, so they hold for arbitrary thermometer content. The value checks assume a residue whose comparator count lies inside the fine flash. Where a bubble is present, they assume it sits at least two levels from the transition. The bench builds every comparator vector from an ideal code and a chosen coarse error, and it skips any combination that would put the count outside 0..2^N2-1+2*EXTRA. Bubbles are placed only at the allowed distance.

// File: rtl/subrange_pkg.sv
// Shared types for the subranging correction logic.
// Assumes nothing beyond IEEE 1800-2017 packages.
package subrange_pkg;

    // Phases of one conversion, in the order they are visited.
    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_HOLD   = 3'd1,
        SEQ_COARSE = 3'd2,
        SEQ_FINE   = 3'd3,
        SEQ_LATCH  = 3'd4
    } seq_state_t;

    // Number of comparators in the fine flash, nominal plus redundant.
    function automatic int therm_width(input int n2, input int extra);
        return (2 ** n2) - 1 + 2 * extra;
    endfunction

endpackage

// File: rtl/subrange_seq.sv
// Conversion sequencer: on start in idle, walks hold, coarse, fine and
// latch phases, one cycle each. Start is ignored in any other phase.
// Assumes a synchronous active-low reset.
module subrange_seq
    import subrange_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic hold_o,
    output logic coarse_strobe_o,
    output logic fine_strobe_o,
    output logic latch_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next phase: a fixed walk, entered only from idle.
    always_comb begin
        case (state_q)
            SEQ_IDLE:   state_d = start_i ? SEQ_HOLD : SEQ_IDLE;
            SEQ_HOLD:   state_d = SEQ_COARSE;
            SEQ_COARSE: state_d = SEQ_FINE;
            SEQ_FINE:   state_d = SEQ_LATCH;
            SEQ_LATCH:  state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // Moore strobes decoded from the phase.
    always_comb begin
        hold_o          = (state_q == SEQ_HOLD) || (state_q == SEQ_COARSE) ||
                          (state_q == SEQ_FINE);
        coarse_strobe_o = (state_q == SEQ_COARSE);
        fine_strobe_o   = (state_q == SEQ_FINE);
        latch_o         = (state_q == SEQ_LATCH);
    end

endmodule

// File: rtl/therm_decoder.sv
// Fine-stage decoder: repairs isolated bubbles by a three-input vote,
// counts asserted comparators, and removes the lower redundancy offset
// (unless POS_ONLY) to give a signed fine value.
// Assumes a bubble has two correct levels between it and the edge.
module therm_decoder #(
    parameter int N2       = 4,
    parameter int EXTRA    = 4,
    parameter bit POS_ONLY = 1'b0,
    parameter int THW      = (2 ** N2) - 1 + 2 * EXTRA,
    parameter int FW       = N2 + 2
) (
    input  logic                 clk,
    input  logic [THW-1:0]       therm_i,
    output logic signed [FW-1:0] fine_val_o
);

    localparam int CW  = $clog2(THW + 1);
    localparam int OFS = POS_ONLY ? 0 : EXTRA;

    logic [THW-1:0] voted;
    logic [CW-1:0]  count;

    // Per-level majority vote with the levels beyond the ends fixed.
    for (genvar i = 0; i < THW; i++) begin : g_vote
        logic below;
        logic above;
        if (i == 0) begin : g_bot
            assign below = 1'b1;
        end else begin : g_mid_lo
            assign below = therm_i[i-1];
        end
        if (i == THW - 1) begin : g_top
            assign above = 1'b0;
        end else begin : g_mid_hi
            assign above = therm_i[i+1];
        end
        assign voted[i] = (below & therm_i[i]) | (below & above) |
                          (therm_i[i] & above);
    end

    // Population count of the repaired vector.
    always_comb begin
        count = '0;
        for (int i = 0; i < THW; i++) begin
            count = count + CW'(voted[i]);
        end
    end

    // Signed fine value relative to the nominal bottom level.
    always_comb begin
        fine_val_o = $signed({{(FW-CW){1'b0}}, count}) - $signed(FW'(OFS));
    end

    // The clock is kept for a uniform interface; the decoder is combinational.
    logic unused_clk;
    assign unused_clk = clk;

endmodule

// File: rtl/code_corrector.sv
// Merges the coarse code with the signed fine value: wraps the fine value
// into N2 bits, moves the coarse code by one step on overrange, and clamps
// the result to the N-bit span. POS_ONLY builds the adder-only variant.
// Assumes the fine value lies in -2^N2 .. 2^(N2+1)-1.
module code_corrector #(
    parameter int N1       = 4,
    parameter int N2       = 4,
    parameter int FW       = N2 + 2,
    parameter bit POS_ONLY = 1'b0
) (
    input  logic [N1-1:0]        coarse_i,
    input  logic signed [FW-1:0] fine_val_i,
    output logic [N1+N2-1:0]     word_o,
    output logic                 sat_o
);

    localparam int N = N1 + N2;

    logic               over;
    logic signed [N1+1:0] adj;

    // Residue above the nominal span.
    assign over = (fine_val_i >= $signed(FW'(2 ** N2)));

    if (POS_ONLY) begin : g_add_only
        // Offset residue: never negative, so the coarse code only increments.
        assign adj = $signed({2'b00, coarse_i}) + $signed({{(N1+1){1'b0}}, over});
    end else begin : g_add_sub
        logic under;
        assign under = fine_val_i[FW-1];
        // Two-sided correction of the coarse code.
        assign adj = $signed({2'b00, coarse_i}) + $signed({{(N1+1){1'b0}}, over})
                   - $signed({{(N1+1){1'b0}}, under});
    end

    // Assemble and clamp the output word.
    always_comb begin
        if (adj[N1+1]) begin
            word_o = '0;
            sat_o  = 1'b1;
        end else if (adj[N1]) begin
            word_o = {N{1'b1}};
            sat_o  = 1'b1;
        end else begin
            word_o = {adj[N1-1:0], fine_val_i[N2-1:0]};
            sat_o  = 1'b0;
        end
    end

endmodule

// File: rtl/subrange_corrector.sv
// Top of the subranging correction logic: sequencer, sampled coarse code,
// sampled fine value, correction and the output register.
// Assumes coarse_i is valid in the coarse_strobe_o cycle and the fine
// comparators are valid in the fine_strobe_o cycle.
module subrange_corrector #(
    parameter int N1       = 4,
    parameter int N2       = 4,
    parameter int EXTRA    = 4,
    parameter bit POS_ONLY = 1'b0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_i,
    input  logic [N1-1:0]                       coarse_i,
    input  logic [(2**N2)-1+2*EXTRA-1:0]        fine_therm_i,
    output logic                                hold_o,
    output logic                                coarse_strobe_o,
    output logic                                fine_strobe_o,
    output logic                                latch_o,
    output logic [N1+N2-1:0]                    result_o,
    output logic                                valid_o,
    output logic                                oor_o
);

    localparam int N   = N1 + N2;
    localparam int THW = subrange_pkg::therm_width(N2, EXTRA);
    localparam int FW  = N2 + 2;

    logic                 cs;
    logic                 fs;
    logic                 ls;
    logic [N1-1:0]        coarse_q;
    logic signed [FW-1:0] fine_now;
    logic signed [FW-1:0] fine_q;
    logic [N-1:0]         corr_word;
    logic                 corr_sat;
    logic [N-1:0]         result_q;
    logic                 valid_q;
    logic                 oor_q;

    subrange_seq i_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .hold_o          (hold_o),
        .coarse_strobe_o (cs),
        .fine_strobe_o   (fs),
        .latch_o         (ls)
    );

    therm_decoder #(
        .N2       (N2),
        .EXTRA    (EXTRA),
        .POS_ONLY (POS_ONLY),
        .THW      (THW),
        .FW       (FW)
    ) i_dec (
        .clk        (clk),
        .therm_i    (fine_therm_i),
        .fine_val_o (fine_now)
    );

    // Coarse code held so it meets the fine value of the same sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
        end else if (cs) begin
            coarse_q <= coarse_i;
        end
    end

    // Fine value captured at the end of the fine phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_q <= '0;
        end else if (fs) begin
            fine_q <= fine_now;
        end
    end

    code_corrector #(
        .N1       (N1),
        .N2       (N2),
        .FW       (FW),
        .POS_ONLY (POS_ONLY)
    ) i_corr (
        .coarse_i   (coarse_q),
        .fine_val_i (fine_q),
        .word_o     (corr_word),
        .sat_o      (corr_sat)
    );

    // Output register, valid pulse and sticky clamp flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            valid_q  <= 1'b0;
            oor_q    <= 1'b0;
        end else begin
            valid_q <= ls;
            if (ls) begin
                result_q <= corr_word;
                if (corr_sat) begin
                    oor_q <= 1'b1;
                end
            end
        end
    end

    assign coarse_strobe_o = cs;
    assign fine_strobe_o   = fs;
    assign latch_o         = ls;
    assign result_o        = result_q;
    assign valid_o         = valid_q;
    assign oor_o           = oor_q;

endmodule

// File: rtl/subrange_corrector_chk.sv
// Protocol checker for subrange_corrector, attached by bind.
// Assumes synchronous reset held for at least one edge.
module subrange_corrector_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         hold_o,
    input logic         coarse_strobe_o,
    input logic         fine_strobe_o,
    input logic         latch_o,
    input logic         valid_o,
    input logic         oor_o,
    input logic [N-1:0] result_o
);

    // R2: coarse phase happens under hold
    a_r2_hold_in_coarse: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_strobe_o |-> hold_o);

    // R2: coarse phase is followed by the fine phase
    a_r2_coarse_then_fine: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_strobe_o |=> fine_strobe_o);

    // R2: fine phase is followed by the latch phase
    a_r2_fine_then_latch: assert property (@(posedge clk) disable iff (!rst_n)
        fine_strobe_o |=> latch_o);

    // R2: phase strobes never overlap
    a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({coarse_strobe_o, fine_strobe_o, latch_o, valid_o}));

    // R8: latch produces a valid pulse one cycle later
    a_r8_latch_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |=> valid_o);

    // R8: valid lasts one cycle
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: result changes only alongside valid
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || $stable(result_o)));

    // R6: clamp flag is sticky
    a_r6_oor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        oor_o |=> oor_o);

endmodule

bind subrange_corrector subrange_corrector_chk #(.N(N1 + N2)) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .hold_o          (hold_o),
    .coarse_strobe_o (coarse_strobe_o),
    .fine_strobe_o   (fine_strobe_o),
    .latch_o         (latch_o),
    .valid_o         (valid_o),
    .oor_o           (oor_o),
    .result_o        (result_o)
);

// File: tb/test_subrange_corrector.sv
`timescale 1ns/1ps
module test_subrange_corrector;

    localparam int N1  = 4;
    localparam int N2  = 4;
    localparam int E   = 4;
    localparam int N   = N1 + N2;
    localparam int THW = (2 ** N2) - 1 + 2 * E;
    localparam int MAXV = (2 ** N) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N1-1:0]  coarse = '0;
    logic [THW-1:0] therm = '0;

    logic         hold_d, cs_d, fs_d, ls_d, valid_d, oor_d;
    logic [N-1:0] res_d;
    logic         hold_p, cs_p, fs_p, ls_p, valid_p, oor_p;
    logic [N-1:0] res_p;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    subrange_corrector #(.N1(N1), .N2(N2), .EXTRA(E), .POS_ONLY(1'b0)) i_subrange_corrector (
        .clk(clk), .rst_n(rst_n), .start_i(start), .coarse_i(coarse), .fine_therm_i(therm),
        .hold_o(hold_d), .coarse_strobe_o(cs_d), .fine_strobe_o(fs_d), .latch_o(ls_d),
        .result_o(res_d), .valid_o(valid_d), .oor_o(oor_d));

    subrange_corrector #(.N1(N1), .N2(N2), .EXTRA(E), .POS_ONLY(1'b1)) i_subrange_corrector_pos (
        .clk(clk), .rst_n(rst_n), .start_i(start), .coarse_i(coarse), .fine_therm_i(therm),
        .hold_o(hold_p), .coarse_strobe_o(cs_p), .fine_strobe_o(fs_p), .latch_o(ls_p),
        .result_o(res_p), .valid_o(valid_p), .oor_o(oor_p));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [THW-1:0] mk(input int cnt);
        logic [THW-1:0] t;
        for (int i = 0; i < THW; i++) t[i] = (i < cnt);
        return t;
    endfunction

    function automatic int clampv(input int x);
        return (x < 0) ? 0 : ((x > MAXV) ? MAXV : x);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run one conversion; returns when valid is seen (or after a timeout).
    task automatic convert(input int c, input logic [THW-1:0] t);
        bit seen = 0;
        @(negedge clk);
        coarse = N1'(c);
        therm  = t;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (valid_d) begin
                seen = 1;
                break;
            end
        end
        if (!seen) chk("R8 valid missing", 0, 1);
    endtask

    // R11: outputs after reset
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R11 result", int'(res_d), 0);
        chk("R11 valid", int'(valid_d), 0);
        chk("R11 oor", int'(oor_d), 0);
        chk("R11 hold", int'(hold_d), 0);
        chk("R11 strobes", int'({cs_d, fs_d, ls_d}), 0);
    endtask

    // R2, R8, R9: phase order, start held high through the conversion
    task automatic t_sequence();
        @(negedge clk);
        coarse = 4'd5;
        therm  = mk(E + 7);
        start  = 1'b1;
        @(negedge clk);
        chk("R2 hold p1", int'({hold_d, cs_d, fs_d, ls_d}), 4'b1000);
        @(negedge clk);
        chk("R9 R2 coarse p2", int'({hold_d, cs_d, fs_d, ls_d}), 4'b1100);
        @(negedge clk);
        chk("R9 R2 fine p3", int'({hold_d, cs_d, fs_d, ls_d}), 4'b1010);
        @(negedge clk);
        chk("R9 R2 latch p4", int'({hold_d, cs_d, fs_d, ls_d}), 4'b0001);
        @(negedge clk);
        start = 1'b0;
        chk("R8 valid", int'(valid_d), 1);
        chk("R1 result", int'(res_d), 87);
        chk("R5 pos result", int'(res_p), 91);
        @(negedge clk);
        chk("R8 valid drop", int'(valid_d), 0);
        chk("R9 idle after latch", int'(hold_d), 0);
        chk("R8 result held", int'(res_d), 87);
    endtask

    // R1, R3, R4, R12: sweep every code with coarse errors of one step
    task automatic t_sweep();
        bit seen [0:MAXV];
        int nseen = 0;
        for (int v = 0; v <= MAXV; v++) seen[v] = 0;
        for (int v = 0; v <= MAXV; v++) begin
            for (int d = -1; d <= 1; d++) begin
                int c = (v >> N2) + d;
                int cnt = v - c * (2 ** N2) + E;
                if (c < 0 || c >= 2 ** N1 || cnt < 0 || cnt > THW) continue;
                convert(c, mk(cnt));
                if (d == 0)       chk("R1 in range", int'(res_d), v);
                else if (d == -1) chk("R3 positive overrange", int'(res_d), v);
                else              chk("R4 negative overrange", int'(res_d), v);
                if (int'(res_d) == v) seen[v] = 1;
            end
        end
        for (int v = 0; v <= MAXV; v++) if (seen[v]) nseen++;
        chk("R12 all codes produced", nseen, MAXV + 1);
    endtask

    // R3, R4: edges of the redundant span
    task automatic t_edges();
        convert(3, mk(E + 16)); chk("R3 wrap to zero", int'(res_d), 64);
        convert(3, mk(E - 1));  chk("R4 all ones fine", int'(res_d), 47);
        convert(3, mk(THW));    chk("R3 top level", int'(res_d), 48 + 15 + E);
        convert(3, mk(0));      chk("R4 bottom level", int'(res_d), 48 - E);
    endtask

    // R5: positive-only variant over the sweep
    task automatic t_pos();
        for (int v = 0; v <= MAXV; v += 3) begin
            for (int d = 0; d <= 1; d++) begin
                int c = (v >> N2) - d;
                int cnt = v - c * (2 ** N2);
                if (c < 0 || cnt > THW) continue;
                convert(c, mk(cnt));
                chk("R5 pos-only", int'(res_p), v);
            end
        end
        convert(5, mk(0));
        chk("R5 no decrement", int'(res_p), 80);
        chk("R4 default decrements", int'(res_d), 80 - E);
    endtask

    // R7: single wrong comparator repaired
    task automatic t_bubble();
        logic [THW-1:0] t;
        t = mk(10); t[7] = 1'b0;
        convert(6, t); chk("R7 zero among ones", int'(res_d), 96 + 6);
        t = mk(10); t[12] = 1'b1;
        convert(6, t); chk("R7 one among zeros", int'(res_d), 96 + 6);
        t = mk(3); t[0] = 1'b0;
        convert(6, t); chk("R7 bottom bubble", int'(res_d), 96 - 1);
        t = mk(0); t[2] = 1'b1;
        convert(6, t); chk("R7 stray above empty", int'(res_d), 96 - E);
    endtask

    // R10: inputs changing after their sampling edge do not matter
    task automatic t_capture();
        @(negedge clk);
        coarse = 4'd2;
        therm  = mk(E + 5);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        coarse = 4'd9;
        @(negedge clk);
        therm = mk(0);
        @(negedge clk);
        chk("R10 valid", int'(valid_d), 1);
        chk("R10 coarse held", int'(res_d), 37);
        chk("R10 pos coarse held", int'(res_p), 41);
    endtask

    // R6: clamping and sticky flag
    task automatic t_sat();
        do_reset();
        convert(15, mk(E + 16));
        chk("R6 clamp high", int'(res_d), MAXV);
        chk("R6 flag high", int'(oor_d), 1);
        chk("R6 pos clamp high", int'(res_p), clampv(240 + E + 16));
        convert(5, mk(E + 3));
        chk("R6 normal after clamp", int'(res_d), 83);
        chk("R6 flag sticky", int'(oor_d), 1);
        do_reset();
        @(negedge clk);
        chk("R6 flag cleared by reset", int'(oor_d), 0);
        convert(0, mk(E - 1));
        chk("R6 clamp low", int'(res_d), 0);
        chk("R6 flag low", int'(oor_d), 1);
        chk("R5 pos no clamp", int'(res_p), E - 1);
        chk("R5 pos flag", int'(oor_p), 0);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_edges();
        t_bubble();
        t_capture();
        t_sweep();
        t_pos();
        t_sat();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule